// File: doc/BRIEF.md
# Command Mailbox Register Slave

This block is a word-addressed register slave placed between a host processor and the manager of a memory subsystem. It carries exactly one command at a time. The host loads up to seven 32-bit argument registers, then posts a request word that names a target interface type, a target instance, a command class and an opcode. Posting that word launches the command: the manager port sees a one-cycle valid strobe together with the decoded request fields and the argument words.

While the request register is nonzero the mailbox is occupied; the host has to see it read zero before posting again. When the manager has finished, it raises a done strobe that carries a status word and three result words. That strobe empties the request register, raises a ready flag in the status register and captures the results. The host polls the ready flag, reads the results, and writes the flag back to zero.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and `mgr_cmd_valid` is low.
- R2: Argument register i (0..6) sits at byte offset 0x438 minus 4*i. It is host-writable at any time, it reads back what was written, and it drives `mgr_params[32*i +: 32]`.
- R3: Writing a nonzero word to the request register (0x43C) while it reads zero stores the word. `mgr_cmd_valid` is high for exactly the one cycle after the write edge. Field layout: `mgr_if_type` = bits 31:29, `mgr_inst_id` = bits 28:24, `mgr_cmd_type` = bits 23:16, `mgr_opcode` = bits 15:0.
- R4: The request register reads back the posted word while the mailbox is occupied. It reads zero after `mgr_done` has been accepted.
- R5: A request write while the request register is nonzero has no effect on the register and produces no strobe. It sets a sticky overrun flag at status bit 8, which only reset clears.
- R6: Writing an all-zero word to the request register while idle produces no strobe and leaves the register at zero.
- R7: An accepted `mgr_done` sets status bit 0 (ready). It copies `mgr_status[7:5]` (command error) and `mgr_status[4:1]` (general error) into the same status bits and `mgr_status[31:16]` (short result) into status bits 31:16. It loads the result words 0, 1 and 2 into offsets 0x458, 0x454 and 0x450. Status bits 15:9 read zero.
- R8: A host write to status (0x45C) with bit 0 at 0 clears the ready flag. A write with bit 0 at 1 does not set it. No other status bit and no result register is host-writable.
- R9: `mgr_done` while the request register is zero is ignored: status and result registers keep their values.
- R10: When `mgr_done` is accepted in the same cycle as a host clear of ready, ready ends up set. When it is accepted in the same cycle as a host request write, that write counts as a write to an occupied mailbox (ignored, overrun set).
- R11: A read returns data on `bus_rdata` in the cycle after `bus_rd`. Offsets not listed above read zero, and `bus_rdata` is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| mgr_cmd_valid | output | 1 | One-cycle command launch strobe |
| mgr_if_type | output | 3 | Target interface type |
| mgr_inst_id | output | 5 | Target instance identifier |
| mgr_cmd_type | output | 8 | Command class |
| mgr_opcode | output | 16 | Command opcode |
| mgr_params | output | 224 | Seven argument words, word i at bits 32*i+31:32*i |
| mgr_done | input | 1 | Command completion acknowledge |
| mgr_status | input | 32 | Completion status word |
| mgr_data | input | 96 | Three result words, word k at bits 32*k+31:32*k |

## Verification
The two functions that can meet in one cycle are the manager's completion and a host access to the register that completion changes. The bench posts a command, then raises `mgr_done` in the same cycle as a host write that clears ready. In a second run it raises `mgr_done` together with a new request write. A behavioural model judges the outcome each cycle, and it is confirmed by read-back: ready stays set in the first case, and in the second the request reads zero, no strobe follows and the overrun bit is set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW      = 32;
  localparam int OVR_BIT = 8;

  typedef struct packed {
    logic [2:0]  if_type;
    logic [4:0]  inst_id;
    logic [7:0]  cmd_type;
    logic [15:0] opcode;
  } mbx_req_t;
endpackage

// File: rtl/mbx_param_bank.sv
module mbx_param_bank #(
  parameter int NPARAM = 7,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPARAM-1:0]    wr_en,
  input  logic [DW-1:0]        wdata,
  output logic [NPARAM*DW-1:0] params
);
  for (genvar i = 0; i < NPARAM; i++) begin : g_arg
    logic [DW-1:0] arg_q;
    always_ff @(posedge clk) begin
      if (rst)           arg_q <= '0;
      else if (wr_en[i]) arg_q <= wdata;
    end
    assign params[i*DW +: DW] = arg_q;
  end
endmodule

// File: rtl/mbx_req_ctrl.sv
module mbx_req_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  input  logic          mgr_done,
  output logic [DW-1:0] req_q,
  output logic          cmd_valid,
  output logic          overrun,
  output logic          done_acc
);
  logic busy;
  logic accept;

  assign busy     = |req_q;
  assign done_acc = mgr_done & busy;
  assign accept   = wr_req & ~busy & (|wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      cmd_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (done_acc)    req_q <= '0;
      else if (accept) req_q <= wdata;
      cmd_valid <= accept;
      if (wr_req && busy) overrun <= 1'b1;
    end
  end

  // R3
  launch_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(req_q) == '0 && req_q != '0));
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !mgr_done) |=> $stable(req_q));
endmodule

// File: rtl/mbx_resp_bank.sv
module mbx_resp_bank #(
  parameter int NDATA = 3,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [DW-1:0]       status_in,
  input  logic [NDATA*DW-1:0] data_in,
  input  logic                clr_wr,
  input  logic                clr_val,
  output logic                rdy_q,
  output logic [6:0]          err_q,
  output logic [15:0]         short_q,
  output logic [NDATA*DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q   <= 1'b0;
      err_q   <= '0;
      short_q <= '0;
    end else if (load) begin
      rdy_q   <= 1'b1;
      err_q   <= status_in[7:1];
      short_q <= status_in[31:16];
    end else if (clr_wr && !clr_val) begin
      rdy_q   <= 1'b0;
    end
  end

  for (genvar k = 0; k < NDATA; k++) begin : g_res
    logic [DW-1:0] res_q;
    always_ff @(posedge clk) begin
      if (rst)       res_q <= '0;
      else if (load) res_q <= data_in[k*DW +: DW];
    end
    assign data_q[k*DW +: DW] = res_q;
  end

  // R7
  load_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> rdy_q);
  // R8
  ready_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(load));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(data_q) && $stable(short_q) && $stable(err_q)));
endmodule

// File: rtl/cmd_mailbox_regs.sv
module cmd_mailbox_regs
  import mbx_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NPARAM   = 7,
  parameter int NDATA    = 3,
  parameter int REQ_OFS  = 'h43C,
  parameter int PAR0_OFS = 'h438,
  parameter int DAT0_OFS = 'h458,
  parameter int STAT_OFS = 'h45C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic                    mgr_cmd_valid,
  output logic [2:0]              mgr_if_type,
  output logic [4:0]              mgr_inst_id,
  output logic [7:0]              mgr_cmd_type,
  output logic [15:0]             mgr_opcode,
  output logic [NPARAM*DW-1:0]    mgr_params,
  input  logic                    mgr_done,
  input  logic [DW-1:0]           mgr_status,
  input  logic [NDATA*DW-1:0]     mgr_data
);
  localparam int WA = AW - 2;
  localparam logic [AW-1:0] REQ_A  = AW'(REQ_OFS);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_OFS);

  logic [WA-1:0]       word;
  logic                hit_req, hit_stat;
  logic [NPARAM-1:0]   hit_par;
  logic [NDATA-1:0]    hit_dat;
  logic [NPARAM-1:0]   par_wr;
  logic [DW-1:0]       req_q;
  logic                overrun, done_acc;
  logic                rdy_q;
  logic [6:0]          err_q;
  logic [15:0]         short_q;
  logic [NDATA*DW-1:0] data_q;
  logic [DW-1:0]       stat_word;
  logic [DW-1:0]       rd_mux;
  mbx_req_t            req_f;

  assign word     = bus_addr[AW-1:2];
  assign hit_req  = (word == REQ_A[AW-1:2]);
  assign hit_stat = (word == STAT_A[AW-1:2]);

  for (genvar i = 0; i < NPARAM; i++) begin : g_par_dec
    localparam logic [AW-1:0] PA = AW'(PAR0_OFS - 4 * i);
    assign hit_par[i] = (word == PA[AW-1:2]);
    assign par_wr[i]  = bus_wr & hit_par[i];
  end

  for (genvar k = 0; k < NDATA; k++) begin : g_dat_dec
    localparam logic [AW-1:0] DA = AW'(DAT0_OFS - 4 * k);
    assign hit_dat[k] = (word == DA[AW-1:2]);
  end

  mbx_param_bank #(.NPARAM(NPARAM), .DW(DW)) u_args (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (par_wr),
    .wdata  (bus_wdata),
    .params (mgr_params)
  );

  mbx_req_ctrl #(.DW(DW)) u_req (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (bus_wr & hit_req),
    .wdata     (bus_wdata),
    .mgr_done  (mgr_done),
    .req_q     (req_q),
    .cmd_valid (mgr_cmd_valid),
    .overrun   (overrun),
    .done_acc  (done_acc)
  );

  mbx_resp_bank #(.NDATA(NDATA), .DW(DW)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .load      (done_acc),
    .status_in (mgr_status),
    .data_in   (mgr_data),
    .clr_wr    (bus_wr & hit_stat),
    .clr_val   (bus_wdata[0]),
    .rdy_q     (rdy_q),
    .err_q     (err_q),
    .short_q   (short_q),
    .data_q    (data_q)
  );

  assign req_f        = mbx_req_t'(req_q);
  assign mgr_if_type  = req_f.if_type;
  assign mgr_inst_id  = req_f.inst_id;
  assign mgr_cmd_type = req_f.cmd_type;
  assign mgr_opcode   = req_f.opcode;

  always_comb begin
    stat_word          = '0;
    stat_word[31:16]   = short_q;
    stat_word[OVR_BIT] = overrun;
    stat_word[7:1]     = err_q;
    stat_word[0]       = rdy_q;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_req)  rd_mux = req_q;
    if (hit_stat) rd_mux = stat_word;
    for (int i = 0; i < NPARAM; i++)
      if (hit_par[i]) rd_mux = mgr_params[i*DW +: DW];
    for (int k = 0; k < NDATA; k++)
      if (hit_dat[k]) rd_mux = data_q[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  // R10
  done_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_acc && bus_wr && hit_stat) |=> rdy_q);
  // R4
  done_empties_req_chk: assert property (@(posedge clk) disable iff (rst)
    done_acc |=> (req_q == '0 && !mgr_cmd_valid));
endmodule

// File: tb/tb_cmd_mailbox_regs.sv
`timescale 1ns/1ps
module tb_cmd_mailbox_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mgr_cmd_valid;
  logic [2:0]  mgr_if_type;
  logic [4:0]  mgr_inst_id;
  logic [7:0]  mgr_cmd_type;
  logic [15:0] mgr_opcode;
  logic [223:0] mgr_params;
  logic        mgr_done = 1'b0;
  logic [31:0] mgr_status = '0;
  logic [95:0] mgr_data = '0;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  cmd_mailbox_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mgr_cmd_valid(mgr_cmd_valid),
    .mgr_if_type(mgr_if_type), .mgr_inst_id(mgr_inst_id), .mgr_cmd_type(mgr_cmd_type),
    .mgr_opcode(mgr_opcode), .mgr_params(mgr_params), .mgr_done(mgr_done),
    .mgr_status(mgr_status), .mgr_data(mgr_data)
  );

  // behavioural reference model
  logic [31:0] m_req = 0, e_rdata = 0;
  logic [31:0] m_par [7];
  logic [31:0] m_dat [3];
  logic [15:0] m_short = 0;
  logic [6:0]  m_err = 0;
  bit          m_rdy = 0, m_ovr = 0, e_valid = 0;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int w = int'(a) & 'hFFC;
    if (w == 'h43C) return m_req;
    if (w == 'h45C) return {m_short, 7'd0, m_ovr, m_err, m_rdy};
    for (int i = 0; i < 7; i++) if (w == 'h438 - 4*i) return m_par[i];
    for (int k = 0; k < 3; k++) if (w == 'h458 - 4*k) return m_dat[k];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    bit busy;
    int w;
    if (rst) begin
      m_req = 0; e_rdata = 0; m_short = 0; m_err = 0; m_rdy = 0; m_ovr = 0; e_valid = 0;
      for (int i = 0; i < 7; i++) m_par[i] = 0;
      for (int k = 0; k < 3; k++) m_dat[k] = 0;
    end else begin
      e_rdata = bus_rd ? m_read(bus_addr) : 32'd0;
      busy = (m_req != 0);
      w = int'(bus_addr) & 'hFFC;
      e_valid = 0;
      if (bus_wr && w == 'h43C) begin
        if (busy) m_ovr = 1;
        else if (bus_wdata != 0) begin m_req = bus_wdata; e_valid = 1; end
      end
      if (mgr_done && busy) begin
        m_req = 0; m_rdy = 1; m_short = mgr_status[31:16]; m_err = mgr_status[7:1];
        for (int k = 0; k < 3; k++) m_dat[k] = mgr_data[32*k +: 32];
      end else if (bus_wr && w == 'h45C && !bus_wdata[0]) m_rdy = 0;
      for (int i = 0; i < 7; i++) if (bus_wr && w == 'h438 - 4*i) m_par[i] = bus_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(bus_rdata === e_rdata, "R11 read data vs model", bus_rdata, e_rdata);
      chk(mgr_cmd_valid === e_valid, "R3 strobe vs model", {31'd0, mgr_cmd_valid}, {31'd0, e_valid});
      if (e_valid)
        chk({mgr_if_type, mgr_inst_id, mgr_cmd_type, mgr_opcode} === m_req, "R3 fields vs model",
            {mgr_if_type, mgr_inst_id, mgr_cmd_type, mgr_opcode}, m_req);
      for (int i = 0; i < 7; i++)
        chk(mgr_params[32*i +: 32] === m_par[i], "R2 argument port vs model", mgr_params[32*i +: 32], m_par[i]);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic done_with(input logic [31:0] st, input bit do_wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    mgr_done = 1; mgr_status = st;
    mgr_data = {32'h33, 32'h22, 32'h11};
    if (do_wr) begin bus_wr = 1; bus_addr = a; bus_wdata = d; end
    @(negedge clk);
    mgr_done = 0; bus_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R1
    chk(mgr_cmd_valid === 1'b0, "R1 strobe low after reset", {31'd0, mgr_cmd_valid}, 0);
    rd('h43C, 0, "R1 request zero");
    rd('h45C, 0, "R1 status zero");
    rd('h438, 0, "R1 argument zero");
    rd('h458, 0, "R1 result zero");
    // R2
    for (int i = 0; i < 7; i++) wr(12'('h438 - 4*i), 32'h1000_0000 + 32'(i) * 32'h111);
    rd('h438, 32'h1000_0000, "R2 argument 0");
    rd('h420, 32'h1000_0666, "R2 argument 6");
    chk(mgr_params[32*6 +: 32] === 32'h1000_0666, "R2 argument 6 port", mgr_params[32*6 +: 32], 32'h1000_0666);
    // R3
    wr('h43C, 32'hB13C_BEEF);
    chk(mgr_cmd_valid === 1'b1, "R3 strobe after post", {31'd0, mgr_cmd_valid}, 1);
    chk({29'd0, mgr_if_type} === 5, "R3 if type", {29'd0, mgr_if_type}, 5);
    chk({27'd0, mgr_inst_id} === 17, "R3 instance", {27'd0, mgr_inst_id}, 17);
    chk({24'd0, mgr_cmd_type} === 'h3C, "R3 cmd type", {24'd0, mgr_cmd_type}, 'h3C);
    chk({16'd0, mgr_opcode} === 'hBEEF, "R3 opcode", {16'd0, mgr_opcode}, 'hBEEF);
    @(negedge clk);
    chk(mgr_cmd_valid === 1'b0, "R3 strobe one cycle", {31'd0, mgr_cmd_valid}, 0);
    // R4
    rd('h43C, 32'hB13C_BEEF, "R4 request busy readback");
    // R5
    wr('h43C, 32'h1234_5678);
    chk(mgr_cmd_valid === 1'b0, "R5 no strobe when busy", {31'd0, mgr_cmd_valid}, 0);
    rd('h43C, 32'hB13C_BEEF, "R5 request unchanged");
    rd('h45C, 32'h0000_0100, "R5 overrun set");
    // R7
    done_with(32'hABCD_00FF, 0, 0, 0);
    rd('h45C, 32'hABCD_01FF, "R7 status loaded");
    rd('h43C, 0, "R4 request cleared by done");
    rd('h458, 32'h11, "R7 result 0");
    rd('h454, 32'h22, "R7 result 1");
    rd('h450, 32'h33, "R7 result 2");
    // R8
    wr('h45C, 32'hFFFF_FFFE);
    rd('h45C, 32'hABCD_01FE, "R8 ready cleared only");
    wr('h45C, 32'h0000_0001);
    rd('h45C, 32'hABCD_01FE, "R8 write one no set");
    wr('h458, 32'h0000_DEAD);
    rd('h458, 32'h11, "R8 result not writable");
    // R6
    wr('h43C, 0);
    chk(mgr_cmd_valid === 1'b0, "R6 zero post no strobe", {31'd0, mgr_cmd_valid}, 0);
    rd('h43C, 0, "R6 request stays zero");
    // R9
    done_with(32'h5555_AAAA, 0, 0, 0);
    rd('h45C, 32'hABCD_01FE, "R9 idle done ignored");
    // R10 done with ready clear
    wr('h43C, 32'h0001_0002);
    done_with(32'h0007_0000, 1, 'h45C, 0);
    rd('h45C, 32'h0007_0101, "R10 done wins over clear");
    // R10 done with request write
    wr('h43C, 32'h0002_0003);
    done_with(32'h0, 1, 'h43C, 32'h5);
    chk(mgr_cmd_valid === 1'b0, "R10 colliding post no strobe", {31'd0, mgr_cmd_valid}, 0);
    rd('h43C, 0, "R10 colliding post ignored");
    rd('h45C, 32'h0000_0101, "R10 overrun kept");
    // R11
    rd('h000, 0, "R11 undefined 0x000");
    rd('h41C, 0, "R11 undefined 0x41C");
    rd('h460, 0, "R11 undefined 0x460");
    @(negedge clk);
    chk(bus_rdata === 0, "R11 idle rdata zero", bus_rdata, 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule